// File: doc/BRIEF.md
# SCSI DMA Byte Handshake Engine

This block moves a stream of bytes between a host DMA request/acknowledge pair and the data lines of a SCSI bus. Each byte crosses the bus under a full REQ/ACK interlock. The engine plays either side of that interlock: as initiator it answers REQ with ACK, and as target it raises REQ and waits for ACK. Software starts a transfer with a one-cycle strobe on one of three inputs: send, target receive or initiator receive. The engine then asks the host for bytes, or offers bytes to it, through a request line. The host flags the last byte by raising end-of-process together with its acknowledge.

The engine is one state machine with four states. `S_IDLE` waits for a start strobe. Send goes to `S_HOST`, and either receive goes to `S_BUS_RISE`. `S_HOST` raises the host request and, on acknowledge, moves to `S_BUS_RISE`. On a receive whose acknowledge carries end-of-process it returns to `S_IDLE` instead. `S_BUS_RISE` waits for the far side's strobe to go high and then moves to `S_BUS_FALL`. `S_BUS_FALL` waits for that strobe to go low. It then goes to `S_HOST`, or to `S_IDLE` after the final outbound byte. From any active state, a bus phase that differs from the programmed phase forces `S_IDLE`, and so does a low DMA-enable. Status flags report completion, last outbound byte and phase mismatch, and they drive an interrupt.

Top module: `scsi_xfer_engine`

## Requirements
- R1: After reset the engine is idle. `dma_drq`, `scsi_req_out`, `scsi_ack_out`, `scsi_data_oe`, `end_dma`, `last_byte_sent`, `phase_err` and `irq` are all 0.
- R2: With `mode_dma_en` high, a one-cycle pulse on `start_send` begins an outbound transfer. A pulse on `start_tgt_rx` or `start_ini_rx` begins an inbound transfer. With `mode_dma_en` low, start pulses are ignored and the engine stays idle.
- R3: With `mode_block` low, `dma_drq` is high only while a byte waits for the host. It falls in the cycle after `dma_dack` is sampled high.
- R4: With `mode_block` high, `dma_drq` stays high from the start of the transfer until the engine returns to idle, including during bus handshakes.
- R5: As initiator (`mode_target` 0), `scsi_ack_out` rises only in the cycle after `scsi_req_in` is sampled high. It falls in the cycle after `scsi_req_in` is sampled low.
- R6: As target (`mode_target` 1), `scsi_req_out` is raised for each byte. It falls in the cycle after `scsi_ack_in` is sampled high, and the byte completes only after `scsi_ack_in` is sampled low.
- R7: On an inbound transfer, `scsi_data_in` is captured in the cycle where the far side's strobe (REQ as initiator, ACK as target) is first sampled low. The captured byte is then offered on `host_rdata` with `dma_drq` high.
- R8: On an outbound transfer, the byte taken from `host_wdata` with `dma_dack` appears on `scsi_data_out`, and `scsi_data_oe` is high while the transfer is active.
- R9: The byte whose `dma_dack` is sampled with `dma_eop` high is the final one. Once its bus or host exchange completes, the engine returns to idle and `end_dma` is set.
- R10: `last_byte_sent` is set at the normal end of an outbound transfer only. It is never set without `end_dma`.
- R11: A mismatch between `bus_phase` and `exp_phase` while active ends the transfer at the next edge and sets both `end_dma` and `phase_err`.
- R12: `irq` is high when `phase_err` is set, or when `end_dma` is set with `mode_eop_irq_en` high. All status flags clear when a new transfer starts.
- R13: Dropping `mode_dma_en` during a transfer returns the engine to idle at the next edge without setting any status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dma_en | input | 1 | DMA operation enable; low aborts |
| mode_block | input | 1 | Hold host request for the whole transfer |
| mode_target | input | 1 | 1 = target role, 0 = initiator role |
| mode_eop_irq_en | input | 1 | Interrupt on normal end of transfer |
| start_send | input | 1 | Start strobe, outbound transfer |
| start_tgt_rx | input | 1 | Start strobe, target receive |
| start_ini_rx | input | 1 | Start strobe, initiator receive |
| exp_phase | input | 3 | Programmed bus phase |
| bus_phase | input | 3 | Observed bus phase lines |
| dma_drq | output | 1 | Host DMA request |
| dma_dack | input | 1 | Host DMA acknowledge |
| dma_eop | input | 1 | End of process, valid with acknowledge |
| host_wdata | input | 8 | Outbound byte from host |
| host_rdata | output | 8 | Inbound byte to host |
| scsi_req_in | input | 1 | Sampled REQ line |
| scsi_ack_in | input | 1 | Sampled ACK line |
| scsi_req_out | output | 1 | REQ drive (target role) |
| scsi_ack_out | output | 1 | ACK drive (initiator role) |
| scsi_data_in | input | 8 | Sampled bus data |
| scsi_data_out | output | 8 | Bus data drive |
| scsi_data_oe | output | 1 | Bus data driver enable |
| end_dma | output | 1 | Transfer ended (normally or by mismatch) |
| last_byte_sent | output | 1 | Final outbound byte completed |
| phase_err | output | 1 | Transfer ended by phase mismatch |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, the strobe ordering of both roles: ACK only after REQ, and REQ dropped only after ACK or an abort. It also checks that the host request falls after an acknowledge in non-block mode, that the abort forces the bus and host lines quiet, that the flags are consistent with each other, and the reset state. Only the bench scenarios can show that the right byte reaches the right side for each role and direction, and that end-of-process picks the final byte. The same holds for block-mode request holding across a whole transfer, for mismatch and abort endings, and for flags clearing on the next start.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_HOST     = 2'd1,
        S_BUS_RISE = 2'd2,
        S_BUS_FALL = 2'd3
    } hs_state_t;
endpackage

// File: rtl/scsi_hs_fsm.sv
module scsi_hs_fsm
    import scsi_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic blk_mode,
    input  logic tgt_mode,
    input  logic go_send,
    input  logic go_recv,
    input  logic phase_ok,
    input  logic peer_in,
    input  logic dack,
    input  logic eop,
    output logic dir_send,
    output logic busy,
    output logic drq,
    output logic own_out,
    output logic ld_host,
    output logic ld_bus,
    output logic ev_start,
    output logic ev_done,
    output logic ev_phase
);
    hs_state_t state, state_nx;
    logic      last_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            dir_send <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (ev_start) begin
                dir_send <= go_send;
                last_q   <= 1'b0;
            end else if (state == S_HOST && dack) begin
                last_q <= eop;
            end
        end
    end

    // Next state and events
    always_comb begin
        state_nx = state;
        ev_start = 1'b0;
        ev_done  = 1'b0;
        ev_phase = 1'b0;
        if (!dma_en) begin
            state_nx = S_IDLE;
        end else if (state != S_IDLE && !phase_ok) begin
            state_nx = S_IDLE;
            ev_phase = 1'b1;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (go_send) begin
                        state_nx = S_HOST;
                        ev_start = 1'b1;
                    end else if (go_recv) begin
                        state_nx = S_BUS_RISE;
                        ev_start = 1'b1;
                    end
                end
                S_HOST: begin
                    if (dack) begin
                        if (!dir_send && eop) begin
                            state_nx = S_IDLE;
                            ev_done  = 1'b1;
                        end else begin
                            state_nx = S_BUS_RISE;
                        end
                    end
                end
                S_BUS_RISE: begin
                    if (peer_in) state_nx = S_BUS_FALL;
                end
                S_BUS_FALL: begin
                    if (!peer_in) begin
                        if (dir_send && last_q) begin
                            state_nx = S_IDLE;
                            ev_done  = 1'b1;
                        end else begin
                            state_nx = S_HOST;
                        end
                    end
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state != S_IDLE);
        drq     = (state == S_HOST) || (blk_mode && busy);
        own_out = tgt_mode ? (state == S_BUS_RISE) : (state == S_BUS_FALL);
        ld_host = (state == S_HOST) && dack && dir_send;
        ld_bus  = (state == S_BUS_FALL) && !peer_in && !dir_send;
    end
endmodule

// File: rtl/scsi_hs_data.sv
module scsi_hs_data #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_host,
    input  logic              ld_bus,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] out_byte,
    output logic [DATA_W-1:0] in_byte
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte <= '0;
            in_byte  <= '0;
        end else begin
            if (ld_host) out_byte <= host_wdata;
            if (ld_bus)  in_byte  <= bus_din;
        end
    end
endmodule

// File: rtl/scsi_hs_status.sv
module scsi_hs_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_done,
    input  logic ev_phase,
    input  logic dir_send,
    input  logic eop_irq_en,
    output logic end_flag,
    output logic last_flag,
    output logic phase_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_flag   <= 1'b0;
            last_flag  <= 1'b0;
            phase_flag <= 1'b0;
        end else if (ev_start) begin
            end_flag   <= 1'b0;
            last_flag  <= 1'b0;
            phase_flag <= 1'b0;
        end else begin
            if (ev_done || ev_phase) end_flag <= 1'b1;
            if (ev_done && dir_send) last_flag <= 1'b1;
            if (ev_phase) phase_flag <= 1'b1;
        end
    end

    assign irq = phase_flag || (end_flag && eop_irq_en);
endmodule

// File: rtl/scsi_xfer_engine.sv
module scsi_xfer_engine #(
    parameter int DATA_W  = 8,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_dma_en,
    input  logic               mode_block,
    input  logic               mode_target,
    input  logic               mode_eop_irq_en,
    input  logic               start_send,
    input  logic               start_tgt_rx,
    input  logic               start_ini_rx,
    input  logic [PHASE_W-1:0] exp_phase,
    input  logic [PHASE_W-1:0] bus_phase,
    output logic               dma_drq,
    input  logic               dma_dack,
    input  logic               dma_eop,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               scsi_req_in,
    input  logic               scsi_ack_in,
    output logic               scsi_req_out,
    output logic               scsi_ack_out,
    input  logic [DATA_W-1:0]  scsi_data_in,
    output logic [DATA_W-1:0]  scsi_data_out,
    output logic               scsi_data_oe,
    output logic               end_dma,
    output logic               last_byte_sent,
    output logic               phase_err,
    output logic               irq
);
    logic peer_in, own_out, busy, dir_send;
    logic ld_host, ld_bus, ev_start, ev_done, ev_phase;

    assign peer_in = mode_target ? scsi_ack_in : scsi_req_in;

    scsi_hs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en   (mode_dma_en),
        .blk_mode (mode_block),
        .tgt_mode (mode_target),
        .go_send  (start_send),
        .go_recv  (start_tgt_rx || start_ini_rx),
        .phase_ok (bus_phase == exp_phase),
        .peer_in  (peer_in),
        .dack     (dma_dack),
        .eop      (dma_eop),
        .dir_send (dir_send),
        .busy     (busy),
        .drq      (dma_drq),
        .own_out  (own_out),
        .ld_host  (ld_host),
        .ld_bus   (ld_bus),
        .ev_start (ev_start),
        .ev_done  (ev_done),
        .ev_phase (ev_phase)
    );

    scsi_hs_data #(.DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_host    (ld_host),
        .ld_bus     (ld_bus),
        .host_wdata (host_wdata),
        .bus_din    (scsi_data_in),
        .out_byte   (scsi_data_out),
        .in_byte    (host_rdata)
    );

    scsi_hs_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (ev_start),
        .ev_done    (ev_done),
        .ev_phase   (ev_phase),
        .dir_send   (dir_send),
        .eop_irq_en (mode_eop_irq_en),
        .end_flag   (end_dma),
        .last_flag  (last_byte_sent),
        .phase_flag (phase_err),
        .irq        (irq)
    );

    assign scsi_req_out = mode_target && own_out;
    assign scsi_ack_out = !mode_target && own_out;
    assign scsi_data_oe = busy && dir_send;
endmodule

// File: rtl/scsi_xfer_engine_chk.sv
module scsi_xfer_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_dma_en,
    input logic       mode_block,
    input logic       mode_target,
    input logic [2:0] exp_phase,
    input logic [2:0] bus_phase,
    input logic       dma_drq,
    input logic       dma_dack,
    input logic       scsi_req_in,
    input logic       scsi_ack_in,
    input logic       scsi_req_out,
    input logic       scsi_ack_out,
    input logic       scsi_data_oe,
    input logic       end_dma,
    input logic       last_byte_sent,
    input logic       phase_err
);
    // R1
    always_ff @(posedge clk)
        if (!rst_n)
            reset_quiet_chk: assert (!dma_drq && !scsi_data_oe && !end_dma && !phase_err);

    // R3
    drq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_block && dma_drq && dma_dack && mode_dma_en && !$past(mode_block)) |=> !dma_drq);

    // R5
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_target && $rose(scsi_ack_out)) |-> $past(scsi_req_in));

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_target && $past(mode_target) && $fell(scsi_req_out) &&
         $past(mode_dma_en) && $past(bus_phase == exp_phase)) |-> $past(scsi_ack_in));

    // R10
    last_implies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte_sent |-> end_dma);

    // R11
    phase_implies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> end_dma);

    // R13
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dma_en |=> (!dma_drq && !scsi_data_oe && !scsi_req_out && !scsi_ack_out));
endmodule

bind scsi_xfer_engine scsi_xfer_engine_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_dma_en    (mode_dma_en),
    .mode_block     (mode_block),
    .mode_target    (mode_target),
    .exp_phase      (exp_phase),
    .bus_phase      (bus_phase),
    .dma_drq        (dma_drq),
    .dma_dack       (dma_dack),
    .scsi_req_in    (scsi_req_in),
    .scsi_ack_in    (scsi_ack_in),
    .scsi_req_out   (scsi_req_out),
    .scsi_ack_out   (scsi_ack_out),
    .scsi_data_oe   (scsi_data_oe),
    .end_dma        (end_dma),
    .last_byte_sent (last_byte_sent),
    .phase_err      (phase_err)
);

// File: tb/test_scsi_xfer_engine.sv
module test_scsi_xfer_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_dma_en = 1'b0, mode_block = 1'b0, mode_target = 1'b0, mode_eop_irq_en = 1'b0;
    logic       start_send = 1'b0, start_tgt_rx = 1'b0, start_ini_rx = 1'b0;
    logic [2:0] exp_phase = 3'd0, bus_phase = 3'd0;
    logic       dma_drq, dma_dack = 1'b0, dma_eop = 1'b0;
    logic [7:0] host_wdata = 8'h00, host_rdata;
    logic       scsi_req_in = 1'b0, scsi_ack_in = 1'b0, scsi_req_out, scsi_ack_out;
    logic [7:0] scsi_data_in = 8'h00, scsi_data_out;
    logic       scsi_data_oe, end_dma, last_byte_sent, phase_err, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scsi_xfer_engine i_scsi_xfer_engine (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // vector: {target, send, block, irq_en, nbytes[3:0], base[7:0]}
    localparam int NVEC = 6;
    localparam logic [15:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 8'h11},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 8'h3C},
        {1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 8'hF0},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 8'h5A},
        {1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 8'h07}
    };

    task automatic bus_step(input bit tgt, input bit snd, input logic [7:0] b);
        if (tgt) begin
            chk("R6 req raised", scsi_req_out, 1);
            if (snd) chk("R8 data out", {scsi_data_oe, scsi_data_out}, {1'b1, b});
            scsi_ack_in = 1'b1; scsi_data_in = b;
            tick();
            chk("R6 req dropped after ack", scsi_req_out, 0);
            scsi_ack_in = 1'b0;
            tick();
        end else begin
            chk("R5 ack waits for req", scsi_ack_out, 0);
            scsi_req_in = 1'b1; scsi_data_in = b;
            tick();
            chk("R5 ack after req", scsi_ack_out, 1);
            if (snd) chk("R8 data out", {scsi_data_oe, scsi_data_out}, {1'b1, b});
            scsi_req_in = 1'b0;
            tick();
            chk("R5 ack released", scsi_ack_out, 0);
        end
    endtask

    task automatic host_step(input bit snd, input bit blk, input bit last, input logic [7:0] b);
        chk("R3 drq for host", dma_drq, 1);
        if (!snd) chk("R7 captured byte", host_rdata, b);
        dma_dack = 1'b1; dma_eop = last; host_wdata = b;
        tick();
        dma_dack = 1'b0; dma_eop = 1'b0;
        chk(blk ? "R4 drq held" : "R3 drq dropped", dma_drq, blk && !(last && !snd));
    endtask

    task automatic run_vec(input logic [15:0] v);
        bit tgt = v[15];
        bit snd = v[14];
        bit blk = v[13];
        int n = int'(v[11:8]);
        mode_target = tgt; mode_block = blk; mode_eop_irq_en = v[12];
        if (snd) start_send = 1'b1;
        else if (tgt) start_tgt_rx = 1'b1;
        else start_ini_rx = 1'b1;
        tick();
        start_send = 1'b0; start_tgt_rx = 1'b0; start_ini_rx = 1'b0;
        chk("R12 flags cleared on start", {end_dma, last_byte_sent, phase_err}, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = v[7:0] + 8'(i * 37);
            bit last = (i == n - 1);
            if (snd) begin
                host_step(1'b1, blk, last, b);
                bus_step(tgt, 1'b1, b);
            end else begin
                bus_step(tgt, 1'b0, b);
                if (blk) chk("R4 drq held in bus phase", dma_drq, 1);
                host_step(1'b0, blk, last, b);
            end
        end
        chk("R9 end flag and idle", {end_dma, dma_drq, scsi_data_oe}, 3'b100);
        chk("R10 last byte sent", last_byte_sent, snd);
        chk("R12 irq on end", irq, v[12]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 reset outputs",
            {dma_drq, scsi_req_out, scsi_ack_out, scsi_data_oe, end_dma, last_byte_sent, phase_err, irq}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", {dma_drq, scsi_data_oe}, 0);

        // R2: start ignored while DMA disabled
        start_send = 1'b1;
        tick();
        start_send = 1'b0;
        chk("R2 start ignored when disabled", {dma_drq, scsi_data_oe}, 0);
        mode_dma_en = 1'b1;
        tick();
        chk("R2 still idle", {dma_drq, scsi_data_oe}, 0);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // R13: abort by clearing DMA enable
        mode_target = 1'b0; mode_block = 1'b0; mode_eop_irq_en = 1'b1;
        start_send = 1'b1;
        tick();
        start_send = 1'b0;
        chk("R2 send started", {dma_drq, scsi_data_oe, end_dma}, 3'b110);
        mode_dma_en = 1'b0;
        tick();
        chk("R13 abort to idle, no flags", {dma_drq, scsi_data_oe, end_dma, irq}, 0);
        mode_dma_en = 1'b1;

        // R11: phase mismatch ends transfer
        mode_eop_irq_en = 1'b0;
        start_ini_rx = 1'b1;
        tick();
        start_ini_rx = 1'b0;
        bus_phase = 3'd1;
        tick();
        chk("R11 mismatch flags", {end_dma, phase_err, last_byte_sent}, 3'b110);
        chk("R12 irq on mismatch", irq, 1);
        scsi_req_in = 1'b1;
        tick();
        chk("R11 engine idle after mismatch", scsi_ack_out, 0);
        scsi_req_in = 1'b0;
        bus_phase = 3'd0;

        // R12: new start clears flags, irq off without enable
        start_tgt_rx = 1'b1; mode_target = 1'b1;
        tick();
        start_tgt_rx = 1'b0;
        chk("R12 flags cleared", {end_dma, phase_err, irq}, 0);
        chk("R6 target raises req", scsi_req_out, 1);
        mode_dma_en = 1'b0;
        tick();
        mode_dma_en = 1'b1;
        chk("R13 req dropped on abort", scsi_req_out, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule